// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Three-Way Compare

This block computes one of eight functions of two 16-bit operands, chosen by a 3-bit operation code. The functions are pass-through of the first operand, addition, subtraction, bitwise AND, bitwise OR, logical shifts in both directions, and a signed three-way compare. One shared adder handles both addition and subtraction. Subtraction inverts the second operand and sets the carry-in. The compare operation takes its ordering from the same difference, corrected for signed overflow. It takes equality from a zero test on the bitwise XOR of the operands.

The datapath is combinational. Following the FPGA convention of registered outputs, the selected value is captured in an output register with a synchronous active-high reset. A result therefore appears one clock after its operands and operation code are presented. New inputs may be applied on every cycle.

The compare result packs three flags into the top three bits of the result: bit 15 for equal, bit 14 for greater and bit 13 for less. All lower bits are zero.

Top module: `alu16_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes 16'h0000 after that edge.
- R2: With `rst` low, the value of `result` after a rising edge is the function selected by the `opcode` sampled at that edge, applied to the `op_a` and `op_b` sampled at that same edge.
- R3: Opcode 3'b000 returns `op_a` unchanged.
- R4: Opcode 3'b001 returns `op_a + op_b` modulo 2^16.
- R5: Opcode 3'b010 returns `op_a - op_b` modulo 2^16, in two's complement.
- R6: Opcode 3'b011 returns the bitwise AND of the operands, and opcode 3'b100 returns their bitwise OR.
- R7: Opcode 3'b101 shifts `op_a` left by `op_b[3:0]` and fills with zeros. `op_b[15:4]` has no effect on the result.
- R8: Opcode 3'b110 shifts `op_a` right by `op_b[3:0]` and fills with zeros, including when bit 15 of `op_a` is set. `op_b[15:4]` has no effect on the result.
- R9: Opcode 3'b111 treats both operands as signed. It sets bit 15 when `op_a == op_b`, bit 14 when `op_a > op_b`, and bit 13 when `op_a < op_b`. Bits 12 to 0 are zero.
- R10: For opcode 3'b111, exactly one of bits 15:13 is set for every operand pair. This includes pairs whose difference overflows 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 16 | First operand; it is the shifted value and the compare's left side |
| op_b | input | 16 | Second operand; its bits 3:0 give the shift amount |
| opcode | input | 3 | Selects the function (see R3 to R9) |
| result | output | 16 | Registered result of the selected function |

## Verification
The assertions assume that `rst` is held high from time zero until at least one rising edge. They also assume that `op_a`, `op_b` and `opcode` carry known values at every sampled edge once reset is released, because each check compares the result with the inputs of the previous edge. The stimulus meets both conditions. It asserts reset from the start and changes the inputs only on falling edges. It never leaves an input undriven, and it includes a mid-run reset with a live opcode applied. The operand patterns aim at the corners of the compare: equal values, pairs with opposite signs whose difference overflows, and the two extreme values. For the shifts they cover every amount, with the upper bits of the amount operand set.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_PASS = 3'b000,
    OP_ADD  = 3'b001,
    OP_SUB  = 3'b010,
    OP_AND  = 3'b011,
    OP_OR   = 3'b100,
    OP_SHL  = 3'b101,
    OP_SHR  = 3'b110,
    OP_CMP  = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu16_addsub.sv
// Shared adder: subtract mode inverts b and injects a carry of one.
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W-1:0] cin_vec;

  assign b_eff   = sub ? ~b : b;
  assign cin_vec = {{(W-1){1'b0}}, sub};
  assign sum     = a + b_eff + cin_vec;
  // Signed overflow: like-signed inputs produce an opposite-signed sum.
  assign ovf     = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu16_shifter.sv
// Logarithmic shifter: one 2:1 multiplexer rank per bit of the amount.
module alu16_shifter #(
  parameter int W    = 16,
  parameter bit LEFT = 1'b1,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stg [0:SHW];

  assign stg[0] = din;

  for (genvar s = 0; s < SHW; s++) begin : g_rank
    if (LEFT) begin : g_l
      assign stg[s+1] = amt[s] ? (stg[s] << (2**s)) : stg[s];
    end else begin : g_r
      assign stg[s+1] = amt[s] ? (stg[s] >> (2**s)) : stg[s];
    end
  end

  assign dout = stg[SHW];
endmodule

// File: rtl/alu16_cmp.sv
// Three-way signed compare packed into the top three bits of a word.
module alu16_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] diff,
  input  logic         ovf,
  output logic [W-1:0] flags
);
  logic eq, lt, gt;

  assign eq = ~(|(a ^ b));
  assign lt = diff[W-1] ^ ovf;
  assign gt = ~eq & ~lt;

  assign flags = {eq, gt, lt, {(W-3){1'b0}}};
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16,
  localparam int SHW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [OPW-1:0] opcode,
  output logic [W-1:0]  result
);
  alu_op_e      op;
  logic         sub_mode;
  logic [W-1:0] arith, shl_v, shr_v, cmp_v;
  logic         ovf;
  logic [W-1:0] sel;

  assign op       = alu_op_e'(opcode);
  assign sub_mode = (op == OP_SUB) || (op == OP_CMP);

  alu16_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(op_b), .sub(sub_mode), .sum(arith), .ovf(ovf)
  );

  alu16_shifter #(.W(W), .LEFT(1'b1)) u_shl (
    .din(op_a), .amt(op_b[SHW-1:0]), .dout(shl_v)
  );

  alu16_shifter #(.W(W), .LEFT(1'b0)) u_shr (
    .din(op_a), .amt(op_b[SHW-1:0]), .dout(shr_v)
  );

  alu16_cmp #(.W(W)) u_cmp (
    .a(op_a), .b(op_b), .diff(arith), .ovf(ovf), .flags(cmp_v)
  );

  always_comb begin
    unique case (op)
      OP_PASS: sel = op_a;
      OP_ADD:  sel = arith;
      OP_SUB:  sel = arith;
      OP_AND:  sel = op_a & op_b;
      OP_OR:   sel = op_a | op_b;
      OP_SHL:  sel = shl_v;
      OP_SHR:  sel = shr_v;
      OP_CMP:  sel = cmp_v;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= sel;
  end
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
  parameter int W = 16,
  localparam int SHW = $clog2(W)
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   opcode,
  input logic [W-1:0] result
);
  // live is high at an edge when the previous edge had reset released.
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result == '0));

  assert_pass_a_R3: assert property (@(posedge clk) disable iff (rst)
    (live && $past(opcode) == 3'b000) |-> (result == $past(op_a)));

  assert_add_R4: assert property (@(posedge clk) disable iff (rst)
    (live && $past(opcode) == 3'b001) |-> (result == W'($past(op_a) + $past(op_b))));

  assert_sub_R5: assert property (@(posedge clk) disable iff (rst)
    (live && $past(opcode) == 3'b010) |-> (result == W'($past(op_a) - $past(op_b))));

  assert_shl_R7: assert property (@(posedge clk) disable iff (rst)
    (live && $past(opcode) == 3'b101) |-> (result == ($past(op_a) << $past(op_b[SHW-1:0]))));

  assert_shr_R8: assert property (@(posedge clk) disable iff (rst)
    (live && $past(opcode) == 3'b110) |-> (result == ($past(op_a) >> $past(op_b[SHW-1:0]))));

  assert_cmp_low_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (live && $past(opcode) == 3'b111) |-> (result[W-4:0] == '0));

  assert_cmp_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    (live && $past(opcode) == 3'b111) |-> ($countones(result[W-1:W-3]) == 1));
endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode), .result(result)
);

// File: tb/test_alu16_core.sv
`timescale 1ns/1ps
module test_alu16_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [2:0]  opcode = '0;
  logic [15:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu16_core i_alu16_core (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode), .result(result)
  );

  function automatic logic [15:0] model(input logic [2:0] op, input logic [15:0] a,
                                        input logic [15:0] b);
    int sa, sb, n;
    sa = $signed(a);
    sb = $signed(b);
    n  = int'(b[3:0]);
    case (op)
      3'd0: return a;
      3'd1: return 16'(int'(a) + int'(b));
      3'd2: return 16'(int'(a) - int'(b));
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return 16'((int'(a) * (1 << n)) % 65536);
      3'd6: return 16'(int'(a) / (1 << n));
      default: begin
        if (sa == sb)     return 16'h8000;
        else if (sa > sb) return 16'h4000;
        else              return 16'h2000;
      end
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9/R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL %s: result=%h expected=%h", req, result, exp);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge (R2 latency).
  task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] exp;
    op_a = a; op_b = b; opcode = op;
    exp = model(op, a, b);
    @(negedge clk);
    check({tag(op), " R2"}, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: result=%h expected=completion", result);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    opcode = 3'd1; op_a = 16'h1234; op_b = 16'h1111;
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);
    rst = 1'b0;

    apply(3'd0, 16'hBEEF, 16'h1234);
    apply(3'd1, 16'hFFFF, 16'h0001);
    apply(3'd1, 16'h7FFF, 16'h0001);
    apply(3'd2, 16'h0000, 16'h0001);
    apply(3'd2, 16'h8000, 16'h0001);
    apply(3'd3, 16'hF0F0, 16'h3C3C);
    apply(3'd4, 16'hF0F0, 16'h3C3C);
    for (int s = 0; s < 16; s++) begin
      apply(3'd5, 16'h8001, 16'hFFF0 | 16'(s)); // R7: upper bits of b set
      apply(3'd6, 16'h8001, 16'hABC0 | 16'(s)); // R8: zero fill, upper b ignored
    end
    // R9/R10 compare corners
    apply(3'd7, 16'h1234, 16'h1234);
    apply(3'd7, 16'h0005, 16'h0003);
    apply(3'd7, 16'hFFFF, 16'h0001);
    apply(3'd7, 16'h8000, 16'h7FFF); // overflowing difference, less
    apply(3'd7, 16'h7FFF, 16'h8000); // overflowing difference, greater
    apply(3'd7, 16'h8000, 16'h8000);
    apply(3'd7, 16'h0000, 16'hFFFF);

    for (int i = 0; i < 600; i++)
      apply(3'(i % 8), 16'($urandom), 16'($urandom));

    // R1 mid-run: reset dominates a live opcode
    op_a = 16'hFFFF; op_b = 16'h0001; opcode = 3'd1; rst = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000);
    rst = 1'b0;
    apply(3'd7, 16'h0001, 16'h0002);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule